// File: doc/BRIEF.md
# RTC Alarm and Interrupt Unit

This block sits next to a real-time seconds/milliseconds counter and turns the counter's values into interrupt events. It watches the current seconds value, the current millisecond-of-second value and a one-cycle millisecond tick. Software programs two seconds-compare alarms, one millisecond-of-second alarm and one millisecond countdown through a simple register read/write port. Every alarm event latches a bit in a status register. A mask register selects which latched bits drive the single level interrupt line.

The counters themselves are outside the block. Status bits are cleared by writing ones to them. A seconds alarm holding zero is treated as switched off. The countdown disarms itself once it expires, so software re-arms it by writing it again.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After a synchronous active-low reset, every register (both seconds alarms, the millisecond alarm, the countdown, mask and status) reads 0 and `irq` is low.
- R2: Register addresses are 0x14 (seconds alarm 0), 0x18 (seconds alarm 1), 0x1C (millisecond alarm), 0x24 (countdown), 0x28 (mask) and 0x2C (status). Each reads back what was last written. Unused bits read 0, and any other address reads 0.
- R3: When `cur_sec` starts to equal a nonzero seconds alarm, status bit 0 (alarm 0) or bit 1 (alarm 1) is set on the next clock edge. The bit is set once per match, so it stays cleared after a clear while the match persists.
- R4: A seconds alarm holding 0 never sets its status bit, even when `cur_sec` is 0.
- R5: The millisecond alarm register has its enable in bit 31 and a target in bits 9:0. On a cycle with `ms_tick` high, enable set and `cur_ms` equal to the target, status bit 2 is set on that edge. With the enable clear, or without a tick, nothing is set.
- R6: The countdown register has its arm bit in bit 31 and a count in bits 27:0. While it is armed, each `ms_tick` lowers the count by one. The tick that takes the count from 1 to 0 (or any tick with an armed count of 0) sets status bit 4, clears the arm bit and leaves the register reading 0. An armed count N of 1 or more therefore fires on the N-th tick.
- R7: Writing 0 to the countdown disarms it, and later ticks set no status bit. A write in the same cycle as a tick takes precedence over the tick.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R9: Status bits are set whatever the mask holds. `irq` is high exactly when a status bit and the same mask bit are both 1, and it is valid in the same cycle that the status register shows the bit.
- R10: The mask stores bits 4:0. Status bit 3 has no event source in this block and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 32 | Current seconds count from the timekeeper |
| cur_ms | input | 10 | Current millisecond within the second |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt, OR of status AND mask |

## Verification
Every event is latched on the clock edge that follows the cycle in which its condition is present. A match, tick or write driven after one falling edge is therefore visible in the status register and on `irq` at the next falling edge, and the bench samples there. Read data depends combinationally on the address, so each read settles a short delay after the address is driven within the low phase of the clock. Countdown expiry is checked by counting ticks from the arming write: the status bit must stay low after N-1 ticks and be high after the N-th.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared register addresses and status bit positions for the
// RTC alarm and interrupt unit. Assumes byte addressing on an 8-bit bus.
package rtc_alarm_pkg;
    localparam logic [7:0] ADDR_SEC_AL0 = 8'h14;
    localparam logic [7:0] ADDR_SEC_AL1 = 8'h18;
    localparam logic [7:0] ADDR_MS_AL   = 8'h1C;
    localparam logic [7:0] ADDR_CDN     = 8'h24;
    localparam logic [7:0] ADDR_MASK    = 8'h28;
    localparam logic [7:0] ADDR_STAT    = 8'h2C;

    localparam int SRC_N       = 5;
    localparam int BIT_SEC_AL0 = 0;
    localparam int BIT_SEC_AL1 = 1;
    localparam int BIT_MS_AL   = 2;
    localparam int BIT_SEC_CDN = 3;
    localparam int BIT_MS_CDN  = 4;
endpackage

// File: rtl/rtc_sec_match.sv
// Module: one seconds-compare alarm. Fires a single-cycle hit when the
// current seconds start to equal a nonzero alarm value.
// Assumes: alarm value of zero means disabled.
module rtc_sec_match #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [SEC_W-1:0] alarm_val,
    output logic             hit
);
    logic match_now;
    logic match_q;

    // Combinational compare, gated off by a zero alarm value
    assign match_now = (alarm_val != '0) && (cur_sec == alarm_val);

    // Remember the previous compare so a hit is reported once per match
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now;
    end

    assign hit = match_now && !match_q;

    AST_ZERO_NEVER_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_val == '0) |-> !hit); // R4
    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R3
endmodule

// File: rtl/rtc_ms_cdn.sv
// Module: millisecond countdown. Counts armed ticks down and fires once,
// disarming itself when it expires.
// Assumes: a register write in the same cycle as a tick wins over the tick.
module rtc_ms_cdn #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic             wr_arm,
    input  logic [CNT_W-1:0] wr_cnt,
    output logic             armed,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Expiry: armed tick with count at one or zero, and no write this cycle
    assign fire = tick && armed && !wr && (cnt <= ONE);

    // Countdown state: write loads, ticks decrement, expiry clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (wr) begin
            armed <= wr_arm;
            cnt   <= wr_cnt;
        end else if (fire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (tick && armed) begin
            cnt   <= cnt - ONE;
        end
    end

    AST_CDN_SELF_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!armed && cnt == '0)); // R6
    AST_CDN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !wr) |=> (!armed && !fire)); // R7
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: mask and write-one-to-clear status registers with a level
// interrupt output. Assumes: a new event wins over a clear of the same bit.
module rtc_irq_ctrl #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         mask_wr,
    input  logic         stat_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr;

    assign clr = stat_wr ? wdata : '0;

    // Mask register: plain load
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wdata;
    end

    // Status register: sticky events, cleared by writing ones
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set_ev;
    end

    assign irq = |(status & mask);

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((status & $past(set_ev)) == $past(set_ev))); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status & $past(wdata & ~set_ev)) == '0)); // R8
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R9
endmodule

// File: rtl/rtc_alarm_irq.sv
// Module: top of the RTC alarm and interrupt unit. Decodes the register
// port, holds alarm registers, and routes events into the status logic.
// Assumes: timekeeping counters live outside; reads are combinational.
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int SEC_W  = 32,
    parameter int MS_W   = 10,
    parameter int CDN_W  = 28,
    parameter int N_SEC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [MS_W-1:0]  cur_ms,
    input  logic             ms_tick,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    localparam int ARM_B = DW - 1;

    logic [SEC_W-1:0] sec_al [N_SEC];
    logic [N_SEC-1:0] sec_hit;
    logic             ms_en;
    logic [MS_W-1:0]  ms_val;
    logic             ms_hit;
    logic             cdn_wr, cdn_armed, cdn_fire;
    logic [CDN_W-1:0] cdn_cnt;
    logic [SRC_N-1:0] set_ev, mask, status;

    // One register and one comparator per seconds alarm
    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        localparam logic [AW-1:0] MY_ADDR = ADDR_SEC_AL0 + AW'(4 * g);

        // Alarm value register
        always_ff @(posedge clk) begin
            if (!rst_n)                            sec_al[g] <= '0;
            else if (reg_we && reg_addr == MY_ADDR) sec_al[g] <= reg_wdata[SEC_W-1:0];
        end

        rtc_sec_match #(.SEC_W(SEC_W)) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_sec   (cur_sec),
            .alarm_val (sec_al[g]),
            .hit       (sec_hit[g])
        );
    end

    // Millisecond alarm register: enable and target value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_en  <= 1'b0;
            ms_val <= '0;
        end else if (reg_we && reg_addr == ADDR_MS_AL) begin
            ms_en  <= reg_wdata[ARM_B];
            ms_val <= reg_wdata[MS_W-1:0];
        end
    end

    assign ms_hit = ms_tick && ms_en && (cur_ms == ms_val);
    assign cdn_wr = reg_we && (reg_addr == ADDR_CDN);

    rtc_ms_cdn #(.CNT_W(CDN_W)) u_cdn (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .wr     (cdn_wr),
        .wr_arm (reg_wdata[ARM_B]),
        .wr_cnt (reg_wdata[CDN_W-1:0]),
        .armed  (cdn_armed),
        .cnt    (cdn_cnt),
        .fire   (cdn_fire)
    );

    // Gather event pulses in status bit order
    always_comb begin
        set_ev              = '0;
        set_ev[BIT_SEC_AL0] = sec_hit[0];
        set_ev[BIT_SEC_AL1] = sec_hit[N_SEC-1];
        set_ev[BIT_MS_AL]   = ms_hit;
        set_ev[BIT_SEC_CDN] = 1'b0;
        set_ev[BIT_MS_CDN]  = cdn_fire;
    end

    rtc_irq_ctrl #(.N(SRC_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .mask_wr (reg_we && reg_addr == ADDR_MASK),
        .stat_wr (reg_we && reg_addr == ADDR_STAT),
        .wdata   (reg_wdata[SRC_N-1:0]),
        .mask    (mask),
        .status  (status),
        .irq     (irq)
    );

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_SEC_AL0: reg_rdata[SEC_W-1:0] = sec_al[0];
            ADDR_SEC_AL1: reg_rdata[SEC_W-1:0] = sec_al[N_SEC-1];
            ADDR_MS_AL: begin
                reg_rdata[ARM_B]    = ms_en;
                reg_rdata[MS_W-1:0] = ms_val;
            end
            ADDR_CDN: begin
                reg_rdata[ARM_B]     = cdn_armed;
                reg_rdata[CDN_W-1:0] = cdn_cnt;
            end
            ADDR_MASK: reg_rdata[SRC_N-1:0] = mask;
            ADDR_STAT: reg_rdata[SRC_N-1:0] = status;
            default:   reg_rdata = '0;
        endcase
    end

    AST_RESERVED_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !status[BIT_SEC_CDN]); // R10
    AST_MS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !(reg_we && reg_addr == ADDR_STAT) && !status[BIT_MS_AL])
        |=> !status[BIT_MS_AL]); // R5
endmodule

// File: tb/rtc_alarm_irq_tb_top.sv
module rtc_alarm_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_sec = '0;
    logic [9:0]  cur_ms = '0;
    logic        ms_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_alarm_irq dut_i (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_ms(cur_ms),
        .ms_tick(ms_tick), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] mk);
        return |(st[4:0] & mk[4:0]);
    endfunction

    function automatic logic [31:0] exp_cdn(input logic arm, input int cnt);
        return {arm, 3'b000, 28'(cnt)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        foreach (d[i]) begin end
        rd(8'h14, d); chk("R1 sec0", d, 0);
        rd(8'h18, d); chk("R1 sec1", d, 0);
        rd(8'h1C, d); chk("R1 msal", d, 0);
        rd(8'h24, d); chk("R1 cdn", d, 0);
        rd(8'h28, d); chk("R1 mask", d, 0);
        rd(8'h2C, d); chk("R1 stat", d, 0);

        // R2: register map and readback
        wr(8'h14, 32'd5);          rd(8'h14, d); chk("R2 sec0", d, 32'd5);
        wr(8'h18, 32'hDEAD_BEEF);  rd(8'h18, d); chk("R2 sec1", d, 32'hDEAD_BEEF);
        wr(8'h1C, 32'hFFFF_FD23);  rd(8'h1C, d); chk("R2 msal", d, 32'h8000_0123);
        wr(8'h30, 32'hFFFF_FFFF);  rd(8'h30, d); chk("R2 unmapped", d, 0);
        // R10: mask keeps bits 4:0 only
        wr(8'h28, 32'hFFFF_FFFF);  rd(8'h28, d); chk("R10 mask", d, 32'h1F);
        wr(8'h28, 32'h0);

        // R3/R9: seconds alarm 0 fires with mask clear
        @(negedge clk); cur_sec = 32'd5;
        @(negedge clk);
        rd(8'h2C, d); chk("R3 sec0 fired", d, 32'h1);
        chk("R9 masked irq", {31'b0, irq}, {31'b0, exp_irq(d, 0)});
        wr(8'h28, 32'h1);
        chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
        // R8: writing 0 leaves status
        wr(8'h2C, 32'h0); rd(8'h2C, d); chk("R8 w0 keeps", d, 32'h1);
        wr(8'h2C, 32'h1); rd(8'h2C, d); chk("R8 w1 clears", d, 32'h0);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd(8'h2C, d); chk("R3 once per match", d, 32'h0);
        // R3: alarm 1
        wr(8'h18, 32'd9);
        @(negedge clk); cur_sec = 32'd9;
        @(negedge clk);
        rd(8'h2C, d); chk("R3 sec1 fired", d, 32'h2);
        wr(8'h2C, 32'h2);

        // R4: zero alarm never fires
        wr(8'h14, 32'h0); wr(8'h18, 32'h0);
        @(negedge clk); cur_sec = 32'd0;
        repeat (3) @(negedge clk);
        rd(8'h2C, d); chk("R4 zero alarm", d, 32'h0);

        // R5: millisecond alarm
        @(negedge clk); cur_ms = 10'h123;
        repeat (2) @(negedge clk);
        rd(8'h2C, d); chk("R5 no tick", d, 32'h0);
        tick();
        rd(8'h2C, d); chk("R5 tick match", d, 32'h4);
        wr(8'h2C, 32'h4);
        wr(8'h1C, 32'h0000_0123);
        tick();
        rd(8'h2C, d); chk("R5 disabled", d, 32'h0);

        // R6: countdown of 3
        wr(8'h24, 32'h8000_0003);
        tick(); tick();
        rd(8'h24, d); chk("R6 cdn after 2", d, exp_cdn(1'b1, 1));
        rd(8'h2C, d); chk("R6 not yet", d, 32'h0);
        tick();
        rd(8'h2C, d); chk("R6 expired", d, 32'h10);
        rd(8'h24, d); chk("R6 disarmed", d, 32'h0);
        wr(8'h2C, 32'h10);
        // R6: armed zero fires on first tick
        wr(8'h24, 32'h8000_0000);
        tick();
        rd(8'h2C, d); chk("R6 armed zero", d, 32'h10);
        wr(8'h2C, 32'h10);

        // R6: random counts
        for (int k = 0; k < 6; k++) begin
            int n;
            n = 1 + int'($urandom_range(19));
            wr(8'h24, exp_cdn(1'b1, n));
            for (int t = 1; t < n; t++) tick();
            rd(8'h2C, d); chk("R6 random early", d, 32'h0);
            tick();
            rd(8'h2C, d); chk("R6 random expire", d, 32'h10);
            wr(8'h2C, 32'h10);
        end

        // R7: writing zero disarms
        wr(8'h24, 32'h8000_0005);
        wr(8'h24, 32'h0);
        repeat (8) tick();
        rd(8'h2C, d); chk("R7 disarmed", d, 32'h0);
        // R7: write in tick cycle wins
        wr(8'h24, 32'h8000_0001);
        @(negedge clk);
        ms_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h8000_0004;
        @(negedge clk);
        ms_tick = 1'b0; reg_we = 1'b0;
        rd(8'h24, d); chk("R7 write wins", d, 32'h8000_0004);
        rd(8'h2C, d); chk("R7 no fire", d, 32'h0);

        // R8: event wins over clear in same cycle
        wr(8'h24, 32'h8000_0001);
        @(negedge clk);
        ms_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h10;
        @(negedge clk);
        ms_tick = 1'b0; reg_we = 1'b0;
        rd(8'h2C, d); chk("R8 set wins", d, 32'h10);

        // R9/R10: random masks against latched status
        wr(8'h14, 32'd40); wr(8'h1C, 32'h8000_0007);
        @(negedge clk); cur_sec = 32'd40; cur_ms = 10'd7;
        tick();
        rd(8'h2C, d); chk("R10 status bits", d, 32'h15);
        for (int k = 0; k < 20; k++) begin
            v = $urandom;
            wr(8'h28, v);
            rd(8'h28, d); chk("R10 mask random", d, v & 32'h1F);
            chk("R9 irq random", {31'b0, irq}, {31'b0, exp_irq(32'h15, v)});
        end

        done = 1;
        summary();
    end
endmodule